// File: doc/BRIEF.md
# Furnace Relay Ringlet Engine

This block runs a small guard-driven state machine, a furnace relay controller, as a chain of atomic ringlets. A single pulse on `step` while the engine is idle starts one ringlet. The ringlet moves through fixed phases, one per clock: it captures the inputs the present state needs into private copies, runs the entry action if the state was just entered, and tests the state's outgoing guard. It then runs the exit or internal step, and finally copies the private relay value to the pin.

Inputs are therefore seen once per ringlet and the output moves once per ringlet. Nothing that happens on the pins in mid-ringlet changes the outcome. The status outputs show which phase is running and which machine state is current, so a host or a monitor can follow the machine ringlet by ringlet.

Top module: `ringlet_engine`

## Requirements
- R1: After synchronous reset the engine is idle. `phase_o` is 0, `state_o` is 0 (start state), `relay_on_out` is 0 and `ringlet_done` is 0.
- R2: A `step` sampled high at a clock edge while `phase_o` is 0 starts a ringlet. `phase_o` then reads 1 (capture), 2 (entry), 3 (guard test), 4 or 5, 6 (publish) and back to 0, one value per cycle. A `step` seen in any other phase has no effect.
- R3: `ringlet_done` is high exactly during the cycle in which `phase_o` is 6.
- R4: `demand_in` and `heat_in` are captured at the clock edge that ends the capture cycle (`phase_o` = 1). Their values at any later point of the same ringlet do not change its outcome.
- R5: State codes are 0 = start, 1 = relay off, 2 = relay on. The start state always moves to relay off. Relay off moves to relay on when the captured demand is 2'b10 and the captured heat is 1. Relay on moves to relay off when the captured demand is 2'b01. In every other case the state stays the same. `state_o` changes only at the edge that ends phase 6.
- R6: `relay_on_out` changes only at the edge that ends phase 6, where it takes the private relay value of that ringlet.
- R7: The entry action runs only in the first ringlet after a state change, and after reset. Entering relay on sets the private relay value to 1, and entering relay off sets it to 0.
- R8: Phase 4 (exit) follows the guard test when a transition fires. Phase 5 (internal) follows when no transition fires.
- R9: In relay on, the heat input is not captured and has no influence. Demand 2'b10 with heat 1 keeps the machine in relay on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Starts one ringlet when idle |
| demand_in | input | 2 | External demand code |
| heat_in | input | 1 | External heat request |
| relay_on_out | output | 1 | Published relay command |
| phase_o | output | 3 | Current ringlet phase code |
| state_o | output | 2 | Current machine state code |
| ringlet_done | output | 1 | High in the publish cycle |

## Verification
The machine is driven through every transition and every holding case. These include a start ringlet, relay off with each half of its guard missing, relay on with the turn-off demand, and relay on with the turn-on pattern. The last case tells a state-specific guard apart from a shared one. Two ringlets change the inputs right after the capture edge, once toward firing and once away from it. This shows whether the decision comes from the captured copy or from the live pins. A held `step` across a whole ringlet shows that a ringlet cannot be restarted or cut short. Watching the relay pin across the first ringlet in a new state separates entry-time updates from publish-time updates.

// File: rtl/ringlet_pkg.sv
package ringlet_pkg;

    localparam int DEMAND_W   = 2;
    localparam int PHASE_W    = 3;
    localparam int STATE_W    = 2;
    localparam logic [DEMAND_W-1:0] DEM_RAISE = 2'b10;
    localparam logic [DEMAND_W-1:0] DEM_DROP  = 2'b01;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE     = 3'd0,
        PH_READ     = 3'd1,
        PH_ENTRY    = 3'd2,
        PH_CHECK    = 3'd3,
        PH_EXIT     = 3'd4,
        PH_INTERNAL = 3'd5,
        PH_WRITE    = 3'd6
    } phase_t;

    typedef enum logic [STATE_W-1:0] {
        ST_START = 2'd0,
        ST_OFF   = 2'd1,
        ST_ON    = 2'd2
    } fsm_state_t;

    typedef struct packed {
        logic dem;
        logic heat;
    } snap_use_t;

    typedef struct packed {
        logic       fire;
        fsm_state_t target;
    } guard_t;

    // Which inputs a state reads during its ringlets.
    function automatic snap_use_t inputs_used(fsm_state_t st);
        snap_use_t u;
        u.dem  = (st == ST_OFF) || (st == ST_ON);
        u.heat = (st == ST_OFF);
        return u;
    endfunction

    // Outgoing guards of each state, highest priority first.
    function automatic guard_t eval_guards(fsm_state_t st,
                                           logic [DEMAND_W-1:0] dem,
                                           logic heat);
        guard_t g;
        g.fire   = 1'b0;
        g.target = st;
        case (st)
            ST_START: begin
                g.fire   = 1'b1;
                g.target = ST_OFF;
            end
            ST_OFF: begin
                if (dem == DEM_RAISE && heat) begin
                    g.fire   = 1'b1;
                    g.target = ST_ON;
                end
            end
            ST_ON: begin
                if (dem == DEM_DROP) begin
                    g.fire   = 1'b1;
                    g.target = ST_OFF;
                end
            end
            default: begin
                g.fire   = 1'b1;
                g.target = ST_START;
            end
        endcase
        return g;
    endfunction

    // Entry action: new private relay value.
    function automatic logic entry_relay(fsm_state_t st, logic cur);
        logic r;
        case (st)
            ST_OFF:  r = 1'b0;
            ST_ON:   r = 1'b1;
            default: r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ringlet_sequencer.sv
module ringlet_sequencer
    import ringlet_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    input  logic   fire,
    output phase_t phase
);
    phase_t phase_n;

    always_comb begin
        phase_n = phase;
        case (phase)
            PH_IDLE:     if (step) phase_n = PH_READ;
            PH_READ:     phase_n = PH_ENTRY;
            PH_ENTRY:    phase_n = PH_CHECK;
            PH_CHECK:    phase_n = fire ? PH_EXIT : PH_INTERNAL;
            PH_EXIT:     phase_n = PH_WRITE;
            PH_INTERNAL: phase_n = PH_WRITE;
            PH_WRITE:    phase_n = PH_IDLE;
            default:     phase_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_n;
    end
endmodule

// File: rtl/ringlet_snapshot.sv
module ringlet_snapshot
    import ringlet_pkg::*;
#(
    parameter int DW = DEMAND_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  snap_use_t     used,
    input  logic [DW-1:0] dem_in,
    input  logic          heat_in,
    output logic [DW-1:0] dem_q,
    output logic          heat_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dem_q  <= '0;
            heat_q <= 1'b0;
        end else if (capture) begin
            if (used.dem)  dem_q  <= dem_in;
            if (used.heat) heat_q <= heat_in;
        end
    end
endmodule

// File: rtl/furnace_machine.sv
module furnace_machine
    import ringlet_pkg::*;
#(
    parameter int DW = DEMAND_W
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_t        phase,
    input  logic [DW-1:0] snap_dem,
    input  logic          snap_heat,
    output fsm_state_t    state,
    output snap_use_t     used,
    output logic          fire,
    output logic          relay_out
);
    logic       entry_pending;
    logic       relay_loc;
    logic       fired_q;
    fsm_state_t target_q;
    guard_t     g;

    always_comb begin
        g    = eval_guards(state, snap_dem, snap_heat);
        fire = g.fire;
        used = inputs_used(state);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_START;
            entry_pending <= 1'b1;
            relay_loc     <= 1'b0;
            fired_q       <= 1'b0;
            target_q      <= ST_START;
            relay_out     <= 1'b0;
        end else begin
            case (phase)
                PH_ENTRY: begin
                    if (entry_pending) relay_loc <= entry_relay(state, relay_loc);
                end
                PH_CHECK: begin
                    fired_q  <= g.fire;
                    target_q <= g.target;
                end
                PH_WRITE: begin
                    relay_out     <= relay_loc;
                    entry_pending <= fired_q;
                    if (fired_q) state <= target_q;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ringlet_engine.sv
module ringlet_engine
    import ringlet_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    input  logic [DEMAND_W-1:0] demand_in,
    input  logic                heat_in,
    output logic                relay_on_out,
    output logic [PHASE_W-1:0]  phase_o,
    output logic [STATE_W-1:0]  state_o,
    output logic                ringlet_done
);
    phase_t              phase;
    fsm_state_t          state;
    snap_use_t           used;
    logic                fire;
    logic [DEMAND_W-1:0] snap_dem;
    logic                snap_heat;

    ringlet_sequencer seq_i (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .fire  (fire),
        .phase (phase)
    );

    ringlet_snapshot #(.DW(DEMAND_W)) snap_i (
        .clk     (clk),
        .rst     (rst),
        .capture (phase == PH_READ),
        .used    (used),
        .dem_in  (demand_in),
        .heat_in (heat_in),
        .dem_q   (snap_dem),
        .heat_q  (snap_heat)
    );

    furnace_machine #(.DW(DEMAND_W)) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .snap_dem  (snap_dem),
        .snap_heat (snap_heat),
        .state     (state),
        .used      (used),
        .fire      (fire),
        .relay_out (relay_on_out)
    );

    assign phase_o      = phase;
    assign state_o      = state;
    assign ringlet_done = (phase == PH_WRITE);
endmodule

// File: rtl/ringlet_checker.sv
module ringlet_checker
    import ringlet_pkg::*;
#(
    parameter int DW = DEMAND_W
) (
    input logic               clk,
    input logic               rst,
    input logic [PHASE_W-1:0] phase_o,
    input logic [STATE_W-1:0] state_o,
    input logic               relay_on_out,
    input logic               ringlet_done,
    input logic [DW-1:0]      snap_dem,
    input logic               snap_heat
);
    p_read_to_entry_r2: assert property (@(posedge clk) disable iff (rst)
        phase_o == PH_READ |=> phase_o == PH_ENTRY);
    p_entry_to_check_r2: assert property (@(posedge clk) disable iff (rst)
        phase_o == PH_ENTRY |=> phase_o == PH_CHECK);
    p_check_branch_r8: assert property (@(posedge clk) disable iff (rst)
        phase_o == PH_CHECK |=> (phase_o == PH_EXIT || phase_o == PH_INTERNAL));
    p_branch_to_write_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_EXIT || phase_o == PH_INTERNAL) |=> phase_o == PH_WRITE);
    p_write_to_idle_r2: assert property (@(posedge clk) disable iff (rst)
        phase_o == PH_WRITE |=> phase_o == PH_IDLE);
    p_done_after_branch_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ringlet_done) |-> ($past(phase_o) == PH_EXIT || $past(phase_o) == PH_INTERNAL));
    p_relay_hold_r6: assert property (@(posedge clk) disable iff (rst)
        phase_o != PH_WRITE |=> $stable(relay_on_out));
    p_state_hold_r5: assert property (@(posedge clk) disable iff (rst)
        phase_o != PH_WRITE |=> $stable(state_o));
    p_snap_hold_r4: assert property (@(posedge clk) disable iff (rst)
        phase_o != PH_READ |=> $stable(snap_dem));
    p_heat_unused_r9: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_ON |=> $stable(snap_heat));
endmodule

bind ringlet_engine ringlet_checker #(.DW(ringlet_pkg::DEMAND_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .phase_o      (phase_o),
    .state_o      (state_o),
    .relay_on_out (relay_on_out),
    .ringlet_done (ringlet_done),
    .snap_dem     (snap_dem),
    .snap_heat    (snap_heat)
);

// File: tb/ringlet_engine_tb.sv
module ringlet_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step = 1'b0;
    logic [1:0] demand_in = 2'b00;
    logic       heat_in = 1'b0;
    logic       relay_on_out;
    logic [2:0] phase_o;
    logic [1:0] state_o;
    logic       ringlet_done;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    // behavioural reference
    int m_phase = 0, m_state = 0, m_entry = 1, m_loc = 0, m_out = 0;
    int m_dem = 0, m_heat = 0, m_fire = 0, m_tgt = 0;

    ringlet_engine dut_i (
        .clk(clk), .rst(rst), .step(step), .demand_in(demand_in),
        .heat_in(heat_in), .relay_on_out(relay_on_out), .phase_o(phase_o),
        .state_o(state_o), .ringlet_done(ringlet_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_state = 0; m_entry = 1; m_loc = 0; m_out = 0;
            m_dem = 0; m_heat = 0; m_fire = 0; m_tgt = 0;
        end else begin
            case (m_phase)
                0: if (step) m_phase = 1;
                1: begin
                    if (m_state != 0) m_dem = demand_in;
                    if (m_state == 1) m_heat = heat_in;
                    m_phase = 2;
                end
                2: begin
                    if (m_entry != 0) begin
                        if (m_state == 1) m_loc = 0;
                        else if (m_state == 2) m_loc = 1;
                    end
                    m_phase = 3;
                end
                3: begin
                    if (m_state == 0) begin m_fire = 1; m_tgt = 1; end
                    else if (m_state == 1) begin m_fire = (m_dem == 2 && m_heat == 1); m_tgt = 2; end
                    else begin m_fire = (m_dem == 1); m_tgt = 1; end
                    m_phase = m_fire ? 4 : 5;
                end
                4, 5: m_phase = 6;
                default: begin
                    m_out = m_loc;
                    if (m_fire != 0) m_state = m_tgt;
                    m_entry = m_fire;
                    m_phase = 0;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && !ended) begin
            check(phase_o == m_phase, "R2 model phase", phase_o, m_phase);
            check(state_o == m_state, "R5 model state", state_o, m_state);
            check(relay_on_out == m_out, "R6 model relay", relay_on_out, m_out);
            check(ringlet_done == (m_phase == 6), "R3 model done", ringlet_done, m_phase == 6);
        end
    end

    // One ringlet: inputs d0/h0 over the capture edge, d1/h1 afterwards.
    task automatic ringlet(input logic [1:0] d0, input logic h0,
                           input logic [1:0] d1, input logic h1,
                           input bit hold_step, output int br_phase, output int mid_relay);
        demand_in = d0; heat_in = h0; step = 1'b1;
        @(negedge clk);
        check(phase_o == 1, "R2 capture phase", phase_o, 1);
        if (!hold_step) step = 1'b0;
        @(negedge clk);
        check(phase_o == 2, "R2 entry phase", phase_o, 2);
        demand_in = d1; heat_in = h1;
        @(negedge clk);
        check(phase_o == 3, "R2 check phase", phase_o, 3);
        @(negedge clk);
        br_phase  = phase_o;
        mid_relay = relay_on_out;
        check(ringlet_done == 0, "R3 done low before publish", ringlet_done, 0);
        @(negedge clk);
        check(phase_o == 6 && ringlet_done == 1, "R3 done in publish", ringlet_done, 1);
        @(negedge clk);
        check(phase_o == 0, "R2 back to idle", phase_o, 0);
        step = 1'b0;
    endtask

    initial begin
        int br, mr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(phase_o == 0 && ringlet_done == 0, "R1 reset phase", phase_o, 0);
        check(state_o == 0, "R1 reset state", state_o, 0);
        check(relay_on_out == 0, "R1 reset relay", relay_on_out, 0);

        // start state always leaves to relay off
        ringlet(2'b11, 1'b1, 2'b11, 1'b1, 0, br, mr);
        check(br == 4, "R8 start fires exit", br, 4);
        check(state_o == 1, "R5 start to off", state_o, 1);

        // off: heat missing -> stays
        ringlet(2'b10, 1'b0, 2'b10, 1'b0, 0, br, mr);
        check(br == 5, "R8 no fire internal", br, 5);
        check(state_o == 1, "R5 off holds without heat", state_o, 1);
        // off: wrong demand -> stays
        ringlet(2'b11, 1'b1, 2'b11, 1'b1, 0, br, mr);
        check(state_o == 1, "R5 off holds wrong demand", state_o, 1);

        // capture beats late change: fire despite late removal
        ringlet(2'b10, 1'b1, 2'b00, 1'b0, 0, br, mr);
        check(state_o == 2, "R4 captured inputs fire", state_o, 2);
        check(relay_on_out == 0, "R7 relay not yet on", relay_on_out, 0);

        // first ring in on: entry sets relay, visible only at publish
        ringlet(2'b00, 1'b0, 2'b00, 1'b0, 1, br, mr);
        check(mr == 0, "R6 relay held mid ringlet", mr, 0);
        check(relay_on_out == 1, "R7 entry on sets relay", relay_on_out, 1);
        @(negedge clk);
        check(phase_o == 0, "R2 held step no restart", phase_o, 0);

        // on ignores heat / raise pattern
        ringlet(2'b10, 1'b1, 2'b10, 1'b1, 0, br, mr);
        check(state_o == 2 && br == 5, "R9 raise pattern ignored in on", state_o, 2);
        // late drop demand has no effect
        ringlet(2'b00, 1'b1, 2'b01, 1'b0, 0, br, mr);
        check(state_o == 2, "R4 late drop ignored", state_o, 2);
        check(relay_on_out == 1, "R7 no re-entry in on", relay_on_out, 1);

        // drop
        ringlet(2'b01, 1'b0, 2'b01, 1'b0, 0, br, mr);
        check(state_o == 1, "R5 on to off", state_o, 1);
        check(relay_on_out == 1, "R6 relay unchanged on exit", relay_on_out, 1);
        ringlet(2'b00, 1'b0, 2'b00, 1'b0, 0, br, mr);
        check(relay_on_out == 0, "R7 entry off clears relay", relay_on_out, 0);

        // idle with no step stays idle and ignores inputs
        demand_in = 2'b10; heat_in = 1'b1;
        repeat (3) @(negedge clk);
        check(phase_o == 0 && state_o == 1, "R2 no step no ringlet", phase_o, 0);

        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!ended) begin
            ended = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule